// File: doc/BRIEF.md
# Tag-Renaming Register File

This block is the speculative register file of an out-of-order core that renames destinations with tags. Each architectural register has one entry that holds either a ready value or the tag of the in-flight instruction that will produce it, in a single shared payload field. When an instruction is decoded, the block gives its destination a fresh tag and marks that register as pending on it. In the same cycle it reads both source registers and returns, for each one, either a value or the tag to wait for.

A result broadcast (tag plus value) resolves every entry that is still waiting on exactly that tag. A broadcast in the same cycle as a decode is forwarded to the decode reads, so decode never sees a tag that is being resolved in that cycle. The block also keeps a committed architectural copy, written by a commit port. A flush reloads every speculative entry from that copy in one cycle, clears all pending tags and restarts tag allocation.

Decode uses a valid/ready handshake. `dec_ready` is low only during a flush cycle, and a decode offered then is not taken. The broadcast and commit ports have no back-pressure: a valid beat is taken in the cycle it is presented, except that a broadcast during a flush has no effect.

Top module: `rrf_rename_regfile`

## Requirements
- R1: After reset, every register reads as ready with value 0, and the first allocated tag is 0.
- R2: A decode accepted with `dec_rd_en` set and `dec_rd` not 0 gets `dec_tag` as its tag. In the next cycle a read of `dec_rd` returns not ready with that tag. The allocator then steps by 1 and wraps modulo 2^TAGW.
- R3: A broadcast whose tag matches a pending entry makes that entry ready with the broadcast value from the next cycle on.
- R4: A source read of a pending register whose tag equals the tag broadcast in the same cycle returns ready with the broadcast value in that cycle.
- R5: A broadcast whose tag differs from an entry's current tag leaves that entry unchanged. An older result therefore cannot overwrite a register that was renamed again later.
- R6: Register 0 always reads as ready with value 0. A decode with destination 0 renames nothing and does not advance the allocator.
- R7: If a register is renamed and its old tag is broadcast in the same cycle, the register ends pending on the new tag.
- R8: A flush makes every register ready with its committed value in the next cycle, including a commit made in the flush cycle itself, and resets the allocator to 0.
- R9: `dec_ready` is low during a flush cycle, and neither a decode nor a broadcast presented in that cycle changes any entry or the allocator.
- R10: Source reads return the register state from before the same decode's own rename, so an instruction that reads and writes the same register sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode request valid |
| dec_ready | output | 1 | Decode can be accepted (low during flush) |
| dec_rs1 | input | 5 | Source 1 register index |
| dec_rs2 | input | 5 | Source 2 register index |
| dec_rd | input | 5 | Destination register index |
| dec_rd_en | input | 1 | Instruction writes a destination |
| dec_tag | output | 4 | Tag given to this decode's destination |
| src1_ready | output | 1 | Source 1 holds a value |
| src1_value | output | 32 | Source 1 value when ready |
| src1_tag | output | 4 | Source 1 pending tag when not ready |
| src2_ready | output | 1 | Source 2 holds a value |
| src2_value | output | 32 | Source 2 value when ready |
| src2_tag | output | 4 | Source 2 pending tag when not ready |
| wb_valid | input | 1 | Result broadcast valid |
| wb_tag | input | 4 | Tag of broadcast result |
| wb_value | input | 32 | Broadcast result value |
| commit_valid | input | 1 | Commit write valid |
| commit_rd | input | 5 | Committed register index |
| commit_value | input | 32 | Committed value |
| flush | input | 1 | Restore all entries from committed state |

## Verification
Renaming is tested with single renames, back-to-back renames of one register and a full lap of the allocator. Together these separate correct tag stepping and wrap-around from a stuck or skipped allocator. Broadcasts are sent with matching tags, stale tags and tags that collide with a same-cycle rename. This distinguishes tag-exact matching and rename priority from a design that resolves by register or lets the older result win. Same-cycle forwarding and same-register source/destination reads are probed in the decode cycle itself, which exposes a missing bypass or a read taken after the rename. Flushes issued with a commit, a decode and a broadcast in the same cycle show whether committed state is restored completely and whether the inputs that must be ignored really are.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  localparam int unsigned RRF_NREG_DEF = 32;
  localparam int unsigned RRF_XLEN_DEF = 32;
  localparam int unsigned RRF_TAGW_DEF = 4;

  // What a source read resolves to
  typedef enum logic [1:0] {
    SRC_ZERO   = 2'd0,
    SRC_BYPASS = 2'd1,
    SRC_ENTRY  = 2'd2
  } rrf_src_e;
endpackage

// File: rtl/rrf_tag_alloc.sv
module rrf_tag_alloc #(
  parameter int unsigned TAGW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_i,
  input  logic            clear_i,
  output logic [TAGW-1:0] tag_o
);
  logic [TAGW-1:0] next_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) next_q <= '0;
    else if (alloc_i)      next_q <= next_q + 1'b1;
  end

  assign tag_o = next_q;
endmodule

// File: rtl/rrf_arch_file.sv
module rrf_arch_file #(
  parameter int unsigned NREG = 32,
  parameter int unsigned XLEN = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [AW-1:0]   wr_idx_i,
  input  logic [XLEN-1:0] wr_val_i,
  output logic [XLEN-1:0] view_o [NREG]
);
  logic [XLEN-1:0] arch_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_arch
    if (g == 0) begin : g_zero
      assign arch_q[g] = '0;
      assign view_o[g] = '0;
    end else begin : g_reg
      logic hit;
      assign hit = wr_i && (wr_idx_i == AW'(g));
      always_ff @(posedge clk) begin
        if (!rst_n)   arch_q[g] <= '0;
        else if (hit) arch_q[g] <= wr_val_i;
      end
      // restore view folds in a commit made in the same cycle
      assign view_o[g] = hit ? wr_val_i : arch_q[g];
    end
  end
endmodule

// File: rtl/rrf_entry.sv
module rrf_entry #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned TAGW = 4,
  localparam int unsigned PW  = (XLEN > TAGW) ? XLEN : TAGW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush_i,
  input  logic [XLEN-1:0] restore_i,
  input  logic            rename_i,
  input  logic [TAGW-1:0] new_tag_i,
  input  logic            wb_valid_i,
  input  logic [TAGW-1:0] wb_tag_i,
  input  logic [XLEN-1:0] wb_value_i,
  output logic            ready_o,
  output logic [XLEN-1:0] value_o,
  output logic [TAGW-1:0] tag_o
);
  logic          ready_q;
  logic [PW-1:0] payload_q;   // value when ready, tag when pending

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q   <= 1'b1;
      payload_q <= '0;
    end else if (flush_i) begin
      ready_q   <= 1'b1;
      payload_q <= PW'(restore_i);
    end else if (rename_i) begin
      ready_q   <= 1'b0;
      payload_q <= PW'(new_tag_i);
    end else if (wb_valid_i && !ready_q && (payload_q[TAGW-1:0] == wb_tag_i)) begin
      ready_q   <= 1'b1;
      payload_q <= PW'(wb_value_i);
    end
  end

  assign ready_o = ready_q;
  assign value_o = payload_q[XLEN-1:0];
  assign tag_o   = payload_q[TAGW-1:0];
endmodule

// File: rtl/rrf_read_port.sv
module rrf_read_port
  import rrf_pkg::*;
#(
  parameter int unsigned NREG = 32,
  parameter int unsigned XLEN = 32,
  parameter int unsigned TAGW = 4,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic [AW-1:0]   idx_i,
  input  logic            e_ready_i [NREG],
  input  logic [XLEN-1:0] e_value_i [NREG],
  input  logic [TAGW-1:0] e_tag_i   [NREG],
  input  logic            wb_valid_i,
  input  logic [TAGW-1:0] wb_tag_i,
  input  logic [XLEN-1:0] wb_value_i,
  output logic            ready_o,
  output logic [XLEN-1:0] value_o,
  output logic [TAGW-1:0] tag_o
);
  rrf_src_e src;
  logic     sel_ready;

  assign sel_ready = e_ready_i[idx_i];

  always_comb begin
    if (idx_i == '0)                                    src = SRC_ZERO;
    else if (!sel_ready && wb_valid_i &&
             (e_tag_i[idx_i] == wb_tag_i))              src = SRC_BYPASS;
    else                                                src = SRC_ENTRY;
  end

  always_comb begin
    tag_o = e_tag_i[idx_i];
    unique case (src)
      SRC_ZERO: begin
        ready_o = 1'b1;
        value_o = '0;
      end
      SRC_BYPASS: begin
        ready_o = 1'b1;
        value_o = wb_value_i;
      end
      default: begin
        ready_o = sel_ready;
        value_o = e_value_i[idx_i];
      end
    endcase
  end
endmodule

// File: rtl/rrf_rename_regfile.sv
module rrf_rename_regfile
  import rrf_pkg::*;
#(
  parameter int unsigned NREG = RRF_NREG_DEF,
  parameter int unsigned XLEN = RRF_XLEN_DEF,
  parameter int unsigned TAGW = RRF_TAGW_DEF,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dec_valid,
  output logic            dec_ready,
  input  logic [AW-1:0]   dec_rs1,
  input  logic [AW-1:0]   dec_rs2,
  input  logic [AW-1:0]   dec_rd,
  input  logic            dec_rd_en,
  output logic [TAGW-1:0] dec_tag,
  output logic            src1_ready,
  output logic [XLEN-1:0] src1_value,
  output logic [TAGW-1:0] src1_tag,
  output logic            src2_ready,
  output logic [XLEN-1:0] src2_value,
  output logic [TAGW-1:0] src2_tag,
  input  logic            wb_valid,
  input  logic [TAGW-1:0] wb_tag,
  input  logic [XLEN-1:0] wb_value,
  input  logic            commit_valid,
  input  logic [AW-1:0]   commit_rd,
  input  logic [XLEN-1:0] commit_value,
  input  logic            flush
);
  logic            dec_fire;
  logic            do_rename;
  logic            wb_live;
  logic [XLEN-1:0] arch_view [NREG];
  logic            e_ready   [NREG];
  logic [XLEN-1:0] e_value   [NREG];
  logic [TAGW-1:0] e_tag     [NREG];

  assign dec_ready = !flush;
  assign dec_fire  = dec_valid && dec_ready;
  assign do_rename = dec_fire && dec_rd_en && (dec_rd != '0);
  assign wb_live   = wb_valid && !flush;

  rrf_tag_alloc #(.TAGW(TAGW)) u_alloc (
    .clk     (clk),
    .rst_n   (rst_n),
    .alloc_i (do_rename),
    .clear_i (flush),
    .tag_o   (dec_tag)
  );

  rrf_arch_file #(.NREG(NREG), .XLEN(XLEN)) u_arch (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (commit_valid),
    .wr_idx_i (commit_rd),
    .wr_val_i (commit_value),
    .view_o   (arch_view)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    rrf_entry #(.XLEN(XLEN), .TAGW(TAGW)) u_ent (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush_i    (flush),
      .restore_i  (arch_view[g]),
      .rename_i   (do_rename && (dec_rd == AW'(g))),
      .new_tag_i  (dec_tag),
      .wb_valid_i (wb_live),
      .wb_tag_i   (wb_tag),
      .wb_value_i (wb_value),
      .ready_o    (e_ready[g]),
      .value_o    (e_value[g]),
      .tag_o      (e_tag[g])
    );
  end

  logic [AW-1:0]   rd_idx   [2];
  logic            rd_ready [2];
  logic [XLEN-1:0] rd_value [2];
  logic [TAGW-1:0] rd_tag   [2];

  assign rd_idx[0] = dec_rs1;
  assign rd_idx[1] = dec_rs2;

  for (genvar p = 0; p < 2; p++) begin : g_rp
    rrf_read_port #(.NREG(NREG), .XLEN(XLEN), .TAGW(TAGW)) u_rp (
      .idx_i      (rd_idx[p]),
      .e_ready_i  (e_ready),
      .e_value_i  (e_value),
      .e_tag_i    (e_tag),
      .wb_valid_i (wb_live),
      .wb_tag_i   (wb_tag),
      .wb_value_i (wb_value),
      .ready_o    (rd_ready[p]),
      .value_o    (rd_value[p]),
      .tag_o      (rd_tag[p])
    );
  end

  assign src1_ready = rd_ready[0];
  assign src1_value = rd_value[0];
  assign src1_tag   = rd_tag[0];
  assign src2_ready = rd_ready[1];
  assign src2_value = rd_value[1];
  assign src2_tag   = rd_tag[1];
endmodule

// File: rtl/rrf_rename_regfile_chk.sv
module rrf_rename_regfile_chk #(
  parameter int unsigned NREG = 32,
  parameter int unsigned XLEN = 32,
  parameter int unsigned TAGW = 4,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dec_valid,
  input logic            dec_ready,
  input logic [AW-1:0]   dec_rs1,
  input logic [AW-1:0]   dec_rd,
  input logic            dec_rd_en,
  input logic [TAGW-1:0] dec_tag,
  input logic            src1_ready,
  input logic [XLEN-1:0] src1_value,
  input logic [TAGW-1:0] src1_tag,
  input logic            src2_ready,
  input logic            wb_valid,
  input logic [TAGW-1:0] wb_tag,
  input logic            flush
);
  logic acc_rn;
  logic acc_zero;
  assign acc_rn   = dec_valid && dec_ready && dec_rd_en && (dec_rd != '0);
  assign acc_zero = dec_valid && dec_ready && dec_rd_en && (dec_rd == '0);

  AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rn |=> dec_tag == $past(dec_tag) + 1'b1) else $error("tag step"); // R2

  AST_RENAMED_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rn |=> ((dec_rs1 != $past(dec_rd)) || flush ||
                (wb_valid && wb_tag == $past(dec_tag)) ||
                (!src1_ready && src1_tag == $past(dec_tag)))) else $error("rename"); // R2

  AST_BYPASS_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !flush && !src1_ready) |-> src1_tag != wb_tag) else $error("bypass"); // R4

  AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_rs1 == '0) |-> (src1_ready && src1_value == '0)) else $error("zero"); // R6

  AST_ZERO_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    acc_zero |=> dec_tag == $past(dec_tag)) else $error("zero alloc"); // R6

  AST_FLUSH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (src1_ready && src2_ready && dec_tag == '0)) else $error("flush"); // R8
endmodule

bind rrf_rename_regfile rrf_rename_regfile_chk #(
  .NREG(NREG), .XLEN(XLEN), .TAGW(TAGW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_ready(dec_ready),
  .dec_rs1(dec_rs1), .dec_rd(dec_rd), .dec_rd_en(dec_rd_en), .dec_tag(dec_tag),
  .src1_ready(src1_ready), .src1_value(src1_value), .src1_tag(src1_tag),
  .src2_ready(src2_ready), .wb_valid(wb_valid), .wb_tag(wb_tag), .flush(flush)
);

// File: tb/rrf_rename_regfile_tb_top.sv
module rrf_rename_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dec_valid, dec_ready, dec_rd_en;
  logic [4:0]  dec_rs1, dec_rs2, dec_rd;
  logic [3:0]  dec_tag, src1_tag, src2_tag, wb_tag;
  logic        src1_ready, src2_ready, wb_valid, commit_valid, flush;
  logic [31:0] src1_value, src2_value, wb_value, commit_value;
  logic [4:0]  commit_rd;

  int n_chk = 0;
  int n_fail = 0;
  logic [3:0] exp_tag;

  always #5 clk = ~clk;

  rrf_rename_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_rs1(dec_rs1), .dec_rs2(dec_rs2), .dec_rd(dec_rd), .dec_rd_en(dec_rd_en),
    .dec_tag(dec_tag), .src1_ready(src1_ready), .src1_value(src1_value),
    .src1_tag(src1_tag), .src2_ready(src2_ready), .src2_value(src2_value),
    .src2_tag(src2_tag), .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value),
    .commit_valid(commit_valid), .commit_rd(commit_rd), .commit_value(commit_value),
    .flush(flush)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Check source 1 (port 1) or source 2 (port 2) as ready with value
  task automatic exp_val(input int port, input logic [31:0] v, input string req);
    if (port == 1) chk(src1_ready && src1_value == v, req, "src1 value",
                       {src1_ready, src1_value[30:0]}, {1'b1, v[30:0]});
    else           chk(src2_ready && src2_value == v, req, "src2 value",
                       {src2_ready, src2_value[30:0]}, {1'b1, v[30:0]});
  endtask

  task automatic exp_pend(input int port, input logic [3:0] t, input string req);
    if (port == 1) chk(!src1_ready && src1_tag == t, req, "src1 pending",
                       {src1_ready, 27'd0, src1_tag}, {1'b0, 27'd0, t});
    else           chk(!src2_ready && src2_tag == t, req, "src2 pending",
                       {src2_ready, 27'd0, src2_tag}, {1'b0, 27'd0, t});
  endtask

  task automatic idle();
    dec_valid = 0; dec_rd_en = 0; dec_rs1 = 0; dec_rs2 = 0; dec_rd = 0;
    wb_valid = 0; wb_tag = 0; wb_value = 0;
    commit_valid = 0; commit_rd = 0; commit_value = 0; flush = 0;
  endtask

  // advance to the next negedge with inputs returned to idle
  task automatic step();
    @(posedge clk); @(negedge clk); idle(); #1;
  endtask

  task automatic rename(input logic [4:0] rd);
    dec_valid = 1; dec_rd_en = 1; dec_rd = rd; #1;
    chk(dec_tag == exp_tag, "R2", "allocated tag", dec_tag, exp_tag);
    if (rd != 0) exp_tag = exp_tag + 1;
  endtask

  task automatic t_reset();
    dec_rs1 = 5; dec_rs2 = 31; #1;
    exp_val(1, 0, "R1"); exp_val(2, 0, "R1");
    chk(dec_tag == 0, "R1", "first tag", dec_tag, 0);
    chk(dec_ready, "R1", "dec_ready", dec_ready, 1);
  endtask

  task automatic t_rename_and_self_read();
    // R10: r4 read while renamed in the same decode returns old contents
    dec_rs1 = 4; rename(4); exp_val(1, 0, "R10");
    step();
    dec_rs1 = 4; #1; exp_pend(1, 0, "R2");
  endtask

  task automatic t_bypass_resolve();
    rename(3); step();                     // r3 pending on tag 1
    dec_rs1 = 3; dec_rs2 = 3; wb_valid = 1; wb_tag = 1; wb_value = 32'hAAAA_0001; #1;
    exp_val(1, 32'hAAAA_0001, "R4"); exp_val(2, 32'hAAAA_0001, "R4");
    step();
    dec_rs2 = 3; #1; exp_val(2, 32'hAAAA_0001, "R3");
  endtask

  task automatic t_stale();
    rename(5); step();                     // tag 2
    rename(5); step();                     // tag 3
    wb_valid = 1; wb_tag = 2; wb_value = 32'hDEAD; step();
    dec_rs1 = 5; #1; exp_pend(1, 3, "R5");
    wb_valid = 1; wb_tag = 3; wb_value = 32'hBEEF; step();
    dec_rs1 = 5; #1; exp_val(1, 32'hBEEF, "R3");
  endtask

  task automatic t_zero();
    dec_rs1 = 0; rename(0); #1; exp_val(1, 0, "R6");
    step();
    chk(dec_tag == exp_tag, "R6", "tag unchanged after rd=0", dec_tag, exp_tag);
    dec_rs2 = 0; #1; exp_val(2, 0, "R6");
  endtask

  task automatic t_collide();
    logic [3:0] old_t, new_t;
    old_t = exp_tag; rename(6); step();
    new_t = exp_tag;
    dec_rs1 = 6; rename(6); wb_valid = 1; wb_tag = old_t; wb_value = 32'h6666; #1;
    exp_val(1, 32'h6666, "R4");
    step();
    dec_rs1 = 6; #1; exp_pend(1, new_t, "R7");
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 16; i++) begin rename(7); step(); end
    dec_rs1 = 7; #1; exp_pend(1, exp_tag - 4'd1, "R2");
    chk(dec_tag == exp_tag, "R2", "tag after full lap", dec_tag, exp_tag);
  endtask

  task automatic t_flush();
    commit_valid = 1; commit_rd = 8; commit_value = 32'h1234; step();
    rename(9); step();
    // flush with a same-cycle commit, decode and broadcast
    flush = 1; commit_valid = 1; commit_rd = 6; commit_value = 32'h55;
    dec_valid = 1; dec_rd_en = 1; dec_rd = 10;
    wb_valid = 1; wb_tag = exp_tag - 4'd1; wb_value = 32'h9999; #1;
    chk(!dec_ready, "R9", "dec_ready during flush", dec_ready, 0);
    step();
    exp_tag = 0;
    dec_rs1 = 8; dec_rs2 = 6; #1;
    exp_val(1, 32'h1234, "R8"); exp_val(2, 32'h55, "R8");
    dec_rs1 = 9; dec_rs2 = 10; #1;
    exp_val(1, 0, "R9"); exp_val(2, 0, "R9");
    dec_rs1 = 5; dec_rs2 = 7; #1;
    exp_val(1, 0, "R8"); exp_val(2, 0, "R8");
    chk(dec_tag == 0, "R8", "tag after flush", dec_tag, 0);
  endtask

  initial begin
    idle(); rst_n = 0; exp_tag = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    t_reset();
    t_rename_and_self_read();
    t_bypass_resolve();
    t_stale();
    t_zero();
    t_collide();
    t_wrap();
    t_flush();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule